// File: doc/BRIEF.md
# Link Service Request Logic

This block watches the strobe and acknowledge pins of a set of link ports whose data path is idle, because no link buffer owns them or because the buffer that owns them is switched off. When a far end starts a transfer on such a port, the block raises a request for that port. A high acknowledge means the far end is waiting to receive, which gives a transmit request. A high strobe means the far end is trying to send, which gives a receive request. Software can then bring the port up without knowing ahead of time which port or which direction will be used.

Each request is qualified by its own mask bit. Ports held out of service by a loopback set-up never raise a request. The masked requests of all ports and both directions are ORed together, and the result is gated by one global mask to form a single level-sensitive service interrupt.

The pin levels pass through a synchronizer before they are used. The request bits and the interrupt therefore follow the pins with a fixed latency. They carry no memory and drop as soon as the pin condition ends.

A single 32-bit register holds all the state software can see. The mask fields in it are writable, and the request fields are read-only reflections of the live condition.

Top module: `link_svc_req`

## Requirements
- R1: The transmit request of port p (register bit 16+p) is 1 exactly when the synchronized acknowledge pin of p is high, the transmit mask of p (bit p) is 1, p is not enabled and p is not in loopback.
- R2: The receive request of port p (register bit 24+p) is 1 exactly when the synchronized strobe pin of p is high, the receive mask of p (bit 8+p) is 1, p is not enabled and p is not in loopback.
- R3: A port counts as enabled only when at least one buffer has its enable bit set and its port-select field equal to that port. An unassigned port, or a port assigned only to disabled buffers, can raise requests.
- R4: A port whose loopback input is 1 raises neither request, whatever its pins, masks and enable state.
- R5: The interrupt is 1 exactly when the global mask is 1 and at least one request bit is 1. It stays 1 for as long as that holds.
- R6: A pin rising with every other condition met shows in the request bit and the interrupt after the second rising clock edge, and not after the first.
- R7: Reset clears every mask bit, so the register reads 0. A write loads bits 1:0 (transmit masks) and bits 9:8 (receive masks) from the write data. The request bits cannot be written, and all other bits read 0.
- R8: Request bits are not latched. Two clock edges after a pin falls, its request bit and the interrupt it caused return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lnk_ack_i | input | NUM_PORTS | Acknowledge pin level for each port |
| lnk_stb_i | input | NUM_PORTS | Strobe pin level for each port |
| buf_en_i | input | NUM_BUFS | Enable bit of each link buffer |
| buf_sel_i | input | NUM_BUFS*PSEL_W | Port-select field of each buffer; buffer b uses bits [b*PSEL_W +: PSEL_W] |
| loopback_i | input | NUM_PORTS | Marks ports that are held in loopback |
| gmask_i | input | 1 | Global interrupt mask; 1 lets the interrupt through |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Status and mask register contents |
| svc_irq_o | output | 1 | Level-sensitive service interrupt |

## Verification
A table of cases drives both pins high against different buffer layouts: unassigned ports, ports assigned to disabled buffers, ports assigned to enabled buffers through either select value, and both buffers on one port. These cases show whether the enable decode looks at assignment and buffer enable together. Further rows keep the layout fixed and change only the per-direction masks, the loopback input or the global mask, so that a swapped mask field, a missing loopback term or a missing global gate each gives a different wrong code. Directed steps then raise and drop one pin and sample after one and after two edges, which separates the correct latency from one stage too few or too many and exposes any latching. Writes of all ones check that the read-only and unused fields stay at zero.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
   localparam int unsigned REG_W   = 32;
   localparam int unsigned FLD_W   = 8;
   localparam int unsigned TXM_LSB = 0;
   localparam int unsigned RXM_LSB = 8;
   localparam int unsigned TXR_LSB = 16;
   localparam int unsigned RXR_LSB = 24;

   // register image, most significant field first
   typedef struct packed {
      logic [FLD_W-1:0] rx_req;
      logic [FLD_W-1:0] tx_req;
      logic [FLD_W-1:0] rx_msk;
      logic [FLD_W-1:0] tx_msk;
   } lsr_reg_t;
endpackage

// File: rtl/lsr_sync.sv
module lsr_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= din;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/lsr_port_decode.sv
module lsr_port_decode #(
   parameter int unsigned NUM_PORTS = 2,
   parameter int unsigned NUM_BUFS  = 2,
   parameter int unsigned PSEL_W    = 1
) (
   input  logic [NUM_BUFS-1:0]        buf_en,
   input  logic [NUM_BUFS*PSEL_W-1:0] buf_sel,
   output logic [NUM_PORTS-1:0]       port_on
);
   always_comb begin
      port_on = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         for (int b = 0; b < NUM_BUFS; b++) begin
            if (buf_en[b] && (buf_sel[b*PSEL_W +: PSEL_W] == PSEL_W'(p)))
               port_on[p] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/lsr_mask_reg.sv
module lsr_mask_reg #(
   parameter int unsigned NUM_PORTS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [NUM_PORTS-1:0] tx_wdata,
   input  logic [NUM_PORTS-1:0] rx_wdata,
   output logic [NUM_PORTS-1:0] tx_msk,
   output logic [NUM_PORTS-1:0] rx_msk
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_msk <= '0;
         rx_msk <= '0;
      end else if (wr) begin
         tx_msk <= tx_wdata;
         rx_msk <= rx_wdata;
      end
   end
endmodule

// File: rtl/link_svc_req.sv
module link_svc_req
   import lsr_pkg::*;
#(
   parameter int unsigned NUM_PORTS   = 2,
   parameter int unsigned NUM_BUFS    = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PSEL_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS-1:0]        lnk_ack_i,
   input  logic [NUM_PORTS-1:0]        lnk_stb_i,
   input  logic [NUM_BUFS-1:0]         buf_en_i,
   input  logic [NUM_BUFS*PSEL_W-1:0]  buf_sel_i,
   input  logic [NUM_PORTS-1:0]        loopback_i,
   input  logic                        gmask_i,
   input  logic                        reg_wr_i,
   input  logic [REG_W-1:0]            reg_wdata_i,
   output logic [REG_W-1:0]            reg_rdata_o,
   output logic                        svc_irq_o
);
   localparam int unsigned PIN_W = 2 * NUM_PORTS;

   if (NUM_PORTS < 1 || NUM_PORTS > FLD_W) begin : g_bad_ports
      $error("link_svc_req: NUM_PORTS must lie in 1..%0d", FLD_W);
   end
   if (NUM_BUFS < 1) begin : g_bad_bufs
      $error("link_svc_req: NUM_BUFS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("link_svc_req: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PORTS-1:0] ack_s, stb_s, port_on, tx_msk, rx_msk;
   logic [NUM_PORTS-1:0] idle, tx_req, rx_req;
   logic                 unused_wbits;
   lsr_reg_t             img;

   lsr_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({lnk_stb_i, lnk_ack_i}),
      .dout ({stb_s, ack_s})
   );

   lsr_port_decode #(.NUM_PORTS(NUM_PORTS), .NUM_BUFS(NUM_BUFS), .PSEL_W(PSEL_W)) u_dec (
      .buf_en (buf_en_i),
      .buf_sel(buf_sel_i),
      .port_on(port_on)
   );

   lsr_mask_reg #(.NUM_PORTS(NUM_PORTS)) u_msk (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr_i),
      .tx_wdata(reg_wdata_i[TXM_LSB +: NUM_PORTS]),
      .rx_wdata(reg_wdata_i[RXM_LSB +: NUM_PORTS]),
      .tx_msk  (tx_msk),
      .rx_msk  (rx_msk)
   );

   assign unused_wbits = ^reg_wdata_i;

   // a port may request only when no enabled buffer owns it and it is not looped back
   assign idle   = ~port_on & ~loopback_i;
   assign tx_req = ack_s & tx_msk & idle;
   assign rx_req = stb_s & rx_msk & idle;

   always_comb begin
      img = '0;
      img.tx_msk[NUM_PORTS-1:0] = tx_msk;
      img.rx_msk[NUM_PORTS-1:0] = rx_msk;
      img.tx_req[NUM_PORTS-1:0] = tx_req;
      img.rx_req[NUM_PORTS-1:0] = rx_req;
   end

   assign reg_rdata_o = img;
   assign svc_irq_o   = gmask_i & (|{tx_req, rx_req});
endmodule

// File: rtl/link_svc_req_chk.sv
module link_svc_req_chk
   import lsr_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_PORTS-1:0] lnk_ack_i,
   input logic [NUM_PORTS-1:0] lnk_stb_i,
   input logic [NUM_PORTS-1:0] loopback_i,
   input logic                 gmask_i,
   input logic                 reg_wr_i,
   input logic [REG_W-1:0]     reg_wdata_i,
   input logic [REG_W-1:0]     reg_rdata_o,
   input logic                 svc_irq_o
);
   logic [NUM_PORTS-1:0] txr, rxr;
   assign txr = reg_rdata_o[TXR_LSB +: NUM_PORTS];
   assign rxr = reg_rdata_o[RXR_LSB +: NUM_PORTS];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      p_tx_needs_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
         txr[p] |-> reg_rdata_o[TXM_LSB + p]);
      p_rx_needs_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
         rxr[p] |-> reg_rdata_o[RXM_LSB + p]);
      p_loop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
         loopback_i[p] |-> !(txr[p] || rxr[p]));
      p_tx_pin_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
         txr[p] |-> $past(lnk_ack_i[p], 2));
      p_rx_pin_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
         rxr[p] |-> $past(lnk_stb_i[p], 2));
   end

   p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !gmask_i |-> !svc_irq_o);
   p_irq_has_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      svc_irq_o |-> (|{txr, rxr}));
   p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_i |=> (reg_rdata_o[TXM_LSB +: NUM_PORTS] == $past(reg_wdata_i[TXM_LSB +: NUM_PORTS]))
                && (reg_rdata_o[RXM_LSB +: NUM_PORTS] == $past(reg_wdata_i[RXM_LSB +: NUM_PORTS])));
endmodule

bind link_svc_req link_svc_req_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lnk_ack_i  (lnk_ack_i),
   .lnk_stb_i  (lnk_stb_i),
   .loopback_i (loopback_i),
   .gmask_i    (gmask_i),
   .reg_wr_i   (reg_wr_i),
   .reg_wdata_i(reg_wdata_i),
   .reg_rdata_o(reg_rdata_o),
   .svc_irq_o  (svc_irq_o)
);

// File: tb/sim_link_svc_req.sv
module sim_link_svc_req;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ack = '0, stb = '0, ben = '0, bsel = '0, lpb = '0;
   logic        gm = 1'b0, wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          n_run = 0, n_fail = 0;

   always #10 clk = ~clk;

   link_svc_req u0 (
      .clk(clk), .rst_n(rst_n), .lnk_ack_i(ack), .lnk_stb_i(stb),
      .buf_en_i(ben), .buf_sel_i(bsel), .loopback_i(lpb), .gmask_i(gm),
      .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .svc_irq_o(irq)
   );

   typedef struct packed {
      logic [1:0] ack, stb, en, sel, lb, txm, rxm;
      logic       gm;
      logic [1:0] etx, erx;
      logic       eirq;
   } vec_t;

   // sel = {buffer1 port, buffer0 port}
   localparam vec_t VECS [11] = '{
      // R1: unassigned port 0 acknowledge
      '{2'b01,2'b00,2'b00,2'b00,2'b00,2'b11,2'b11,1'b1,2'b01,2'b00,1'b1},
      // R2: port 1 strobe
      '{2'b00,2'b10,2'b00,2'b00,2'b00,2'b11,2'b11,1'b1,2'b00,2'b10,1'b1},
      // R3: buffer0 enabled on port 0, buffer1 disabled on port 0
      '{2'b11,2'b11,2'b01,2'b00,2'b00,2'b11,2'b11,1'b1,2'b10,2'b10,1'b1},
      // R3: port 1 assigned to disabled buffer1
      '{2'b11,2'b11,2'b01,2'b10,2'b00,2'b11,2'b11,1'b1,2'b10,2'b10,1'b1},
      // R3: both ports enabled
      '{2'b11,2'b11,2'b11,2'b10,2'b00,2'b11,2'b11,1'b1,2'b00,2'b00,1'b0},
      // R4: port 0 in loopback
      '{2'b11,2'b11,2'b00,2'b00,2'b01,2'b11,2'b11,1'b1,2'b10,2'b10,1'b1},
      // R1/R2: direction masks differ
      '{2'b11,2'b11,2'b00,2'b00,2'b00,2'b01,2'b00,1'b1,2'b01,2'b00,1'b1},
      // R5: global mask off
      '{2'b01,2'b00,2'b00,2'b00,2'b00,2'b11,2'b11,1'b0,2'b01,2'b00,1'b0},
      // R1/R2: every mask off
      '{2'b11,2'b11,2'b00,2'b00,2'b00,2'b00,2'b00,1'b1,2'b00,2'b00,1'b0},
      // R3: buffer0 enabled on port 1
      '{2'b11,2'b11,2'b01,2'b01,2'b00,2'b11,2'b11,1'b1,2'b01,2'b01,1'b1},
      // R2: receive mask on port 1 only
      '{2'b11,2'b10,2'b00,2'b00,2'b00,2'b00,2'b10,1'b1,2'b00,2'b10,1'b1}
   };

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic write_masks(input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #4_000_000;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R7 reset rdata", rdata, 32'h0);
      check("R7 reset irq", {31'b0, irq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 after reset", rdata, 32'h0);

      for (int i = 0; i < 11; i++) begin
         vec_t v = VECS[i];
         @(negedge clk);
         ack = v.ack; stb = v.stb; ben = v.en; bsel = v.sel; lpb = v.lb; gm = v.gm;
         write_masks({22'b0, v.rxm, 6'b0, v.txm});
         repeat (3) @(negedge clk);
         check($sformatf("R1 tx req vec %0d", i), {30'b0, rdata[17:16]}, {30'b0, v.etx});
         check($sformatf("R2 rx req vec %0d", i), {30'b0, rdata[25:24]}, {30'b0, v.erx});
         check($sformatf("R5 irq vec %0d", i), {31'b0, irq}, {31'b0, v.eirq});
      end

      // R7: request and unused bits ignore writes
      @(negedge clk);
      ack = '0; stb = '0; ben = '0; lpb = '0; gm = 1'b1;
      write_masks(32'hFFFF_FFFF);
      repeat (3) @(negedge clk);
      check("R7 write all ones", rdata, 32'h0000_0303);
      write_masks(32'h0);
      check("R7 write zero", rdata, 32'h0);

      // R6: latency of a rising acknowledge
      write_masks(32'h0000_0303);
      repeat (3) @(negedge clk);
      ack = 2'b10;
      @(negedge clk);
      check("R6 one edge irq", {31'b0, irq}, 32'h0);
      check("R6 one edge req", {30'b0, rdata[17:16]}, 32'h0);
      @(negedge clk);
      check("R6 two edges irq", {31'b0, irq}, 32'h1);
      check("R6 two edges req", {30'b0, rdata[17:16]}, 32'h2);

      // R5: level held
      repeat (10) @(negedge clk);
      check("R5 level held", {31'b0, irq}, 32'h1);

      // R8: drop two edges after pin falls
      ack = 2'b00;
      @(negedge clk);
      check("R8 one edge after fall", {31'b0, irq}, 32'h1);
      @(negedge clk);
      check("R8 irq cleared", {31'b0, irq}, 32'h0);
      check("R8 req cleared", {30'b0, rdata[17:16]}, 32'h0);

      // R6/R8: strobe pulse on port 0
      stb = 2'b01;
      @(negedge clk);
      stb = 2'b00;
      @(negedge clk);
      check("R6 strobe pulse seen", {30'b0, rdata[25:24]}, 32'h1);
      @(negedge clk);
      check("R8 strobe pulse gone", {30'b0, rdata[25:24]}, 32'h0);

      finish_run();
   end
endmodule